// File: doc/BRIEF.md
# Quadrature Carrier Mixer with Pipelined Rotation Oscillator

This block shifts a real intermediate-frequency sample stream down to baseband. Each accepted input sample is multiplied by the cosine and by the negated sine of a carrier phase, which gives an in-phase and a quadrature output sample for every input sample. The carrier phase comes from an accumulator that adds a tuning word once per accepted sample. The cosine and sine are not read from a table. A rotation-mode CORDIC produces them, with one register after each micro-rotation, so a new phase can enter on every clock. The outputs are meant to feed a decimating filter chain that runs at the input rate.

A phase word of 2^PHASE_W stands for one full turn. The two top bits of the phase fold the angle into the range -90 to +90 degrees, and a sign flag records the fold and is applied to the result. The gain of the micro-rotation chain is cancelled by the start value of x, so the carrier has unit amplitude in Q1.(DATA_W-1). The sample and the fold flag travel through the same number of registers as the rotation, so each sample meets the carrier computed for its own phase. A carrier at 30/200 of the sample rate needs tuning word 644245094, which is 0.15 of a turn.

Both streams use valid/ready. A transfer happens on a rising edge where valid and ready are both high. The pipeline moves forward on any clock where the output register is empty or the consumer is ready. `in_ready` equals `!out_valid || out_ready`, so the producer stalls only while a finished result is waiting to be taken.

Top module: `nco_mixer`

## Requirements
- R1: A synchronous reset clears the phase accumulator and every pipeline valid bit. On the clock after reset `out_valid` is 0 and `in_ready` is 1.
- R2: The k-th accepted sample after reset (k = 0, 1, ...) is mixed with phase p_k, where p_0 = 0 and p_(k+1) = (p_k + tune_word) mod 2^32. `tune_word` is read on the accepting edge.
- R3: For a sample s with phase p and angle a = 2·pi·p/2^32, `out_i` ≈ s·cos(a) and `out_q` ≈ -s·sin(a), both in LSBs of the signed DATA_W-bit format. Each output is within 4 LSB of the exact value.
- R4: While `out_ready` is held high, `in_ready` stays high, so one sample is accepted every clock. Each sample's output transfer comes exactly ITER+3 clocks after its input transfer.
- R5: Tuning word 644245094 (0.15 turn per sample, 30 MHz at 200 MHz) is supplied as a package constant and down-converts that carrier.
- R6: Phases in all four quadrants give the correct signs. With tune_word = 2^30 and a constant input A, the outputs cycle (A,0), (0,-A), (-A,0), (0,A).
- R7: The outputs are rounded and saturated symmetrically, so neither output is ever -2^(DATA_W-1). An input of -2^(DATA_W-1) at phase 0 gives `out_i` = -(2^(DATA_W-1)-1).
- R8: While `out_valid` is high and `out_ready` is low, `out_i` and `out_q` hold their values, `in_ready` is low, and no sample is lost or duplicated.
- R9: An input sample of 0 gives exactly 0 on both outputs.
- R10: A clock with `in_valid` low produces no output and does not advance the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | PHASE_W | Phase increment per accepted sample |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DATA_W | Signed IF sample |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Consumer takes the output pair |
| out_i | output | DATA_W | Signed in-phase sample |
| out_q | output | DATA_W | Signed quadrature sample |

## Verification
Assertions check on every cycle that a stalled output holds still, that `in_ready` is high whenever the output register is empty, and that the output never reaches the negative full-scale code. They also check that the accumulator does not move without an accepted sample, that a zero sample leaves the mixer as exactly zero, and that the residual angle after the last micro-rotation is small. The carrier accuracy can only be shown by the bench's scenarios, which compare each output with cosine and sine computed from the running phase. The same holds for the quadrant signs, the fixed ITER+3 latency, and the order of samples under bubbles and back-pressure.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Carrier at 30 MHz with a 200 MHz sample clock, as a 32-bit phase step
  localparam logic [31:0] TUNE_30M_200M = 32'(longint'((30.0 / 200.0) * 4294967296.0));

  // Micro-rotation angle atan(2^-i) expressed in phase units of 2^pw per turn
  function automatic longint atan_word(input int i, input int pw);
    real a;
    a = $atan(1.0 / (2.0 ** i));
    return longint'(a / TWO_PI * (2.0 ** pw));
  endfunction

  // Start value of x that cancels the gain of the rotation chain
  function automatic longint x_init(input int iters, input real scale);
    real k;
    k = 1.0;
    for (int i = 0; i < iters; i++) k = k / $sqrt(1.0 + 2.0 ** (-2 * i));
    return longint'(k * scale);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PW = 32,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [PW-1:0]        tune_word,
  output logic                 v_o,
  output logic [PW-1:0]        z_o,
  output logic                 neg_o,
  output logic signed [DW-1:0] d_o
);
  logic [PW-1:0] acc;
  logic          fold;
  logic          take;

  // Quadrants two and three are turned by half a turn; the sign is restored later
  assign fold = acc[PW-1] ^ acc[PW-2];
  assign take = adv && in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      v_o <= 1'b0;
    end else begin
      if (adv)  v_o <= in_valid;
      if (take) acc <= acc + tune_word;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      z_o   <= {acc[PW-1] ^ fold, acc[PW-2:0]};
      neg_o <= fold;
      d_o   <= in_data;
    end
  end

  a_r10_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(acc));

endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
  parameter int          CW   = 22,
  parameter int          PW   = 32,
  parameter int          DW   = 16,
  parameter int          SH   = 0,
  parameter logic [PW-1:0] ATAN = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 v_i,
  input  logic signed [CW-1:0] x_i,
  input  logic signed [CW-1:0] y_i,
  input  logic [PW-1:0]        z_i,
  input  logic                 neg_i,
  input  logic signed [DW-1:0] d_i,
  output logic                 v_o,
  output logic signed [CW-1:0] x_o,
  output logic signed [CW-1:0] y_o,
  output logic [PW-1:0]        z_o,
  output logic                 neg_o,
  output logic signed [DW-1:0] d_o
);
  logic                 cw_dir;
  logic signed [CW-1:0] x_sh;
  logic signed [CW-1:0] y_sh;

  assign cw_dir = z_i[PW-1];
  assign x_sh   = x_i >>> SH;
  assign y_sh   = y_i >>> SH;

  always_ff @(posedge clk) begin
    if (rst)      v_o <= 1'b0;
    else if (adv) v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      if (cw_dir) begin
        x_o <= x_i + y_sh;
        y_o <= y_i - x_sh;
        z_o <= z_i + ATAN;
      end else begin
        x_o <= x_i - y_sh;
        y_o <= y_i + x_sh;
        z_o <= z_i - ATAN;
      end
      neg_o <= neg_i;
      d_o   <= d_i;
    end
  end

endmodule

// File: rtl/nco_cordic.sv
module nco_cordic #(
  parameter int PW    = 32,
  parameter int DW    = 16,
  parameter int ITER  = 16,
  parameter int GUARD = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic                        v_i,
  input  logic [PW-1:0]               z_i,
  input  logic                        neg_i,
  input  logic signed [DW-1:0]        d_i,
  output logic                        v_o,
  output logic signed [DW+GUARD+1:0]  cos_o,
  output logic signed [DW+GUARD+1:0]  sin_o,
  output logic                        neg_o,
  output logic signed [DW-1:0]        d_o
);
  localparam int CW  = DW + GUARD + 2;
  localparam int AMP = 2 ** (DW - 1) - 1;
  localparam logic signed [CW-1:0] X0 =
    CW'(nco_mix_pkg::x_init(ITER, real'(AMP) * (2.0 ** GUARD)));
  localparam logic [PW-1:0] ZTOL =
    PW'(2 * nco_mix_pkg::atan_word(ITER - 1, PW) + ITER);

  logic signed [CW-1:0] xa [ITER+1];
  logic signed [CW-1:0] ya [ITER+1];
  logic [PW-1:0]        za [ITER+1];
  logic                 va [ITER+1];
  logic                 na [ITER+1];
  logic signed [DW-1:0] da [ITER+1];
  logic [PW-1:0]        z_mag;

  assign xa[0] = X0;
  assign ya[0] = '0;
  assign za[0] = z_i;
  assign va[0] = v_i;
  assign na[0] = neg_i;
  assign da[0] = d_i;

  for (genvar g = 0; g < ITER; g++) begin : g_stage
    nco_cordic_stage #(
      .CW(CW), .PW(PW), .DW(DW), .SH(g),
      .ATAN(PW'(nco_mix_pkg::atan_word(g, PW)))
    ) u_st (
      .clk(clk), .rst(rst), .adv(adv),
      .v_i(va[g]), .x_i(xa[g]), .y_i(ya[g]), .z_i(za[g]), .neg_i(na[g]), .d_i(da[g]),
      .v_o(va[g+1]), .x_o(xa[g+1]), .y_o(ya[g+1]), .z_o(za[g+1]), .neg_o(na[g+1]), .d_o(da[g+1])
    );
  end

  assign v_o   = va[ITER];
  assign cos_o = xa[ITER];
  assign sin_o = ya[ITER];
  assign neg_o = na[ITER];
  assign d_o   = da[ITER];

  assign z_mag = za[ITER][PW-1] ? -za[ITER] : za[ITER];

  // R3: the rotation has converged to the requested angle
  a_r3_residual: assert property (@(posedge clk) disable iff (rst)
    va[ITER] |-> (z_mag <= ZTOL));

endmodule

// File: rtl/nco_mix_mult.sv
module nco_mix_mult #(
  parameter int DW    = 16,
  parameter int GUARD = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adv,
  input  logic                       v_i,
  input  logic signed [DW+GUARD+1:0] cos_i,
  input  logic signed [DW+GUARD+1:0] sin_i,
  input  logic                       neg_i,
  input  logic signed [DW-1:0]       d_i,
  output logic                       out_v,
  output logic signed [DW-1:0]       out_i,
  output logic signed [DW-1:0]       out_q
);
  localparam int CW  = DW + GUARD + 2;
  localparam int PWD = 2 * DW + 1;
  localparam int AMP = 2 ** (DW - 1) - 1;
  localparam logic signed [CW-1:0]  C_HALF = CW'(2 ** (GUARD - 1));
  localparam logic signed [CW-1:0]  C_MAX  = CW'(AMP);
  localparam logic signed [PWD-1:0] P_HALF = PWD'(2 ** (DW - 2));
  localparam logic signed [PWD-1:0] P_MAX  = PWD'(AMP);
  localparam logic signed [DW-1:0]  MINV   = {1'b1, {(DW-1){1'b0}}};

  function automatic logic signed [DW-1:0] carrier_q(input logic signed [CW-1:0] v);
    logic signed [CW-1:0] t;
    t = (v + C_HALF) >>> GUARD;
    if (t > C_MAX)       t = C_MAX;
    else if (t < -C_MAX) t = -C_MAX;
    return t[DW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] prod_q(input logic signed [DW-1:0] a,
                                                   input logic signed [DW-1:0] b);
    logic signed [PWD-1:0] p;
    p = PWD'(a) * PWD'(b);
    p = (p + P_HALF) >>> (DW - 1);
    if (p > P_MAX)       p = P_MAX;
    else if (p < -P_MAX) p = -P_MAX;
    return p[DW-1:0];
  endfunction

  logic signed [DW-1:0] c_r;
  logic signed [DW-1:0] c_rot;
  logic signed [DW-1:0] s_r;
  logic signed [DW-1:0] s_rot;
  logic                 vc;
  logic signed [DW-1:0] cq;
  logic signed [DW-1:0] nsq;
  logic signed [DW-1:0] dc;

  assign c_r   = carrier_q(cos_i);
  assign s_r   = carrier_q(sin_i);
  assign c_rot = neg_i ? -c_r : c_r;
  assign s_rot = neg_i ? s_r : -s_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      vc    <= 1'b0;
      out_v <= 1'b0;
    end else if (adv) begin
      vc    <= v_i;
      out_v <= vc;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      cq    <= c_rot;
      nsq   <= s_rot;
      dc    <= d_i;
      out_i <= prod_q(dc, cq);
      out_q <= prod_q(dc, nsq);
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_v && !adv) |=> (out_v && $stable(out_i) && $stable(out_q)));

  a_r7_no_min: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_i != MINV && out_q != MINV));

  a_r9_zero: assert property (@(posedge clk) disable iff (rst)
    (adv && vc && dc == '0) |=> (out_i == '0 && out_q == '0));

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
  parameter int PHASE_W = 32,
  parameter int DATA_W  = 16,
  parameter int ITER    = 16,
  parameter int GUARD   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       tune_word,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);
  localparam int CW = DATA_W + GUARD + 2;

  logic                     adv;
  logic                     a_v;
  logic [PHASE_W-1:0]       a_z;
  logic                     a_neg;
  logic signed [DATA_W-1:0] a_d;
  logic                     r_v;
  logic signed [CW-1:0]     r_cos;
  logic signed [CW-1:0]     r_sin;
  logic                     r_neg;
  logic signed [DATA_W-1:0] r_d;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  nco_phase_acc #(.PW(PHASE_W), .DW(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .adv(adv), .in_valid(in_valid), .in_data(in_data),
    .tune_word(tune_word), .v_o(a_v), .z_o(a_z), .neg_o(a_neg), .d_o(a_d)
  );

  nco_cordic #(.PW(PHASE_W), .DW(DATA_W), .ITER(ITER), .GUARD(GUARD)) u_rot (
    .clk(clk), .rst(rst), .adv(adv), .v_i(a_v), .z_i(a_z), .neg_i(a_neg), .d_i(a_d),
    .v_o(r_v), .cos_o(r_cos), .sin_o(r_sin), .neg_o(r_neg), .d_o(r_d)
  );

  nco_mix_mult #(.DW(DATA_W), .GUARD(GUARD)) u_mul (
    .clk(clk), .rst(rst), .adv(adv), .v_i(r_v), .cos_i(r_cos), .sin_i(r_sin),
    .neg_i(r_neg), .d_i(r_d), .out_v(out_valid), .out_i(out_i), .out_q(out_q)
  );

  a_r8_ready: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

endmodule

// File: tb/sim_nco_mixer.sv
module sim_nco_mixer;
  localparam int DW   = 16;
  localparam int PW   = 32;
  localparam int ITER = 16;
  localparam int LAT  = ITER + 3;
  localparam int TOL  = 4;
  localparam real TPI = 6.283185307179586;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [PW-1:0]        tune_word = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic signed [DW-1:0] out_i;
  logic signed [DW-1:0] out_q;

  always #5 clk = ~clk;

  nco_mixer #(.PHASE_W(PW), .DATA_W(DW), .ITER(ITER)) u0 (
    .clk(clk), .rst(rst), .tune_word(tune_word), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit lat_mode = 1'b0;
  logic [PW-1:0] ref_ph = '0;
  int q_d[$];
  longint q_ph[$];
  int q_cyc[$];
  bit q_lat[$];
  bit prev_stall = 1'b0;
  int prev_i = 0;
  int prev_q = 0;
  int seed = 12345;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_out();
    int d, ei, eq;
    longint ph;
    real a;
    if (q_d.size() == 0) begin
      chk(1'b0, "R10", "output with no pending sample", int'(out_valid), 0);
      return;
    end
    d = q_d.pop_front();
    ph = q_ph.pop_front();
    a = real'(ph) * TPI / 4294967296.0;
    ei = $rtoi($floor(real'(d) * $cos(a) + 0.5));
    eq = $rtoi($floor(-real'(d) * $sin(a) + 0.5));
    chk((int'(out_i) - ei <= TOL) && (ei - int'(out_i) <= TOL), "R3", "I (phase per R2)", int'(out_i), ei);
    chk((int'(out_q) - eq <= TOL) && (eq - int'(out_q) <= TOL), "R3", "Q (phase per R2)", int'(out_q), eq);
    chk(out_i != -32768 && out_q != -32768, "R7", "negative full scale", int'(out_i), -32767);
    if (d == 0) chk(out_i == 0 && out_q == 0, "R9", "zero sample", int'(out_i) + int'(out_q), 0);
    if (q_lat.pop_front()) chk(cyc - q_cyc.pop_front() == LAT, "R4", "latency", cyc, LAT);
    else void'(q_cyc.pop_front());
  endtask

  task automatic step(input bit v, input int d, input bit rdy);
    @(negedge clk);
    in_valid  = v;
    in_data   = DW'(d);
    out_ready = rdy;
    #1;
    cyc++;
    if (prev_stall)
      chk(out_valid && int'(out_i) == prev_i && int'(out_q) == prev_q, "R8", "held output", int'(out_i), prev_i);
    if (out_valid && !out_ready) chk(!in_ready, "R8", "in_ready under stall", int'(in_ready), 0);
    if (out_ready) chk(in_ready, "R4", "in_ready with consumer ready", int'(in_ready), 1);
    prev_stall = out_valid && !out_ready;
    prev_i = int'(out_i);
    prev_q = int'(out_q);
    if (out_valid && out_ready) compare_out();
    if (in_valid && in_ready) begin
      q_d.push_back(d);
      q_ph.push_back(longint'(ref_ph));
      q_cyc.push_back(cyc);
      q_lat.push_back(lat_mode);
      ref_ph = ref_ph + tune_word;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && q_d.size() > 0; i++) step(1'b0, 0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b1);
    chk(!out_valid && q_d.size() == 0, "R10", "idle after drain", int'(out_valid), 0);
  endtask

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'hFFFF;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

    // R5: tuning constant for 30/200 of a turn
    chk(nco_mix_pkg::TUNE_30M_200M == 32'd644245094, "R5", "tuning constant",
        int'(nco_mix_pkg::TUNE_30M_200M), 644245094);

    // R4, R5: full rate at the 30 MHz setting
    tune_word = nco_mix_pkg::TUNE_30M_200M;
    lat_mode = 1'b1;
    for (int i = 0; i < 200; i++) step(1'b1, 20000, 1'b1);
    drain();
    lat_mode = 1'b0;

    // R6: quarter-turn steps visit every quadrant
    tune_word = 32'h4000_0000;
    for (int i = 0; i < 16; i++) step(1'b1, 30000, 1'b1);
    drain();
    tune_word = 32'hC000_0000;
    for (int i = 0; i < 16; i++) step(1'b1, -25000, 1'b1);
    drain();

    // R3, R2: varied samples at an odd step
    tune_word = 32'h1234_5679;
    for (int i = 0; i < 300; i++) step(1'b1, next_rand() - 32768, 1'b1);
    drain();

    // R10: bubbles in the input stream
    tune_word = 32'h0A3D_70A4;
    for (int i = 0; i < 300; i++) step((next_rand() & 3) != 0, next_rand() - 32768, 1'b1);
    drain();

    // R8: consumer back-pressure
    tune_word = 32'h2222_2222;
    for (int i = 0; i < 400; i++) step((next_rand() & 7) != 0, next_rand() - 32768, (next_rand() & 3) != 0);
    for (int i = 0; i < 30; i++) step(1'b1, 1234 * i - 17000, 1'b0);
    drain();

    // R7: negative full scale at phase zero, R9: zero samples
    tune_word = 32'h0000_0000;
    for (int i = 0; i < 8; i++) step(1'b1, -32768, 1'b1);
    drain();
    tune_word = 32'h3333_3333;
    for (int i = 0; i < 20; i++) step(1'b1, 0, 1'b1);
    drain();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule